// File: doc/BRIEF.md
# Reset Cause and Request Register

This block holds a single 32-bit word that tells boot software why the machine last came out of reset, and lets that software ask for a new reset. Five bits at the top of the word carry meaning. Three of them are cause flags that software clears by writing ones: a power-on flag and two button flags. The other two are request flags that writes can only set: a software power-on request and a software externally-initiated reset request. The remaining bits always read as zero.

Writing a one to the software power-on request bit does three things. It sets that bit, it clears a small power-on counter, and it asks the system for a reset. Writing a one to the external-reset request bit asks for a reset but leaves the counter alone.

The counter records how many system resets the block has seen. It is zero at power-up, and it stops at its maximum value instead of wrapping. When a system reset event arrives while the counter is zero, the word is reloaded with only the power-on flag set. Any later event leaves the word as it is. This is how a software power-on request makes the next reset report itself as a power-on reset.

The word sits at one 8-byte slot of a local register space and answers only in the upper 32-bit half of that slot. The two button flags have set inputs so that a test can drive them.

Top module: `rst_cause_reg`

## Requirements
- R1: After the hardware reset `rst_n` is deasserted, the word reads 0, `por_count` is 0 and `sys_rst_req` is 0.
- R2: A write has an effect only when `addr[15:3]` equals 0x1E04 (byte offsets 0xF020 to 0xF027) and `addr[2]` is 1. A write anywhere else leaves the word and the counter unchanged and produces no request pulse.
- R3: Bits 31 (power-on flag), 28 (button power-on flag) and 27 (button external-reset flag) are cleared where the written data holds a one. A zero written to any of these bits leaves it unchanged.
- R4: Bits 30 (software power-on request) and 29 (software external-reset request) are ORed with the written data, so a write cannot clear them. Bits 26:0 are ignored on write and always read 0.
- R5: A decoded write with bit 30 set clears `por_count` to 0. On the following cycle `sys_rst_req` is 1.
- R6: A decoded write with bit 29 set and bit 30 clear gives `sys_rst_req` = 1 on the following cycle and leaves `por_count` unchanged.
- R7: `sys_rst_req` is high for exactly one cycle for each requesting write. It is 0 after any write that sets neither bit 30 nor bit 29.
- R8: On a `sys_rst_evt` cycle, if `por_count` is 0 the word becomes 0x80000000. In every case `por_count` increments.
- R9: On a `sys_rst_evt` cycle with a non-zero `por_count`, the word keeps its contents.
- R10: `por_count` saturates at 2^CNT_W-1 and does not wrap back to 0.
- R11: `rd_data` shows the word when the decode of R2 holds, and shows 0 for the lower word (`addr[2]` = 0) and for every other address.
- R12: `btn_por_set` sets bit 28 and `btn_xir_set` sets bit 27 in the same cycle's update. When a set coincides with a one-clear of the same bit, the set wins.
- R13: When a write and `sys_rst_evt` arrive in the same cycle, the event is applied and the write is discarded. No request pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset of the block itself |
| addr | input | ADDR_W | Byte offset for both read and write |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from `addr` |
| sys_rst_evt | input | 1 | One-cycle indication that a system reset took place |
| btn_por_set | input | 1 | Test hook that sets the button power-on flag |
| btn_xir_set | input | 1 | Test hook that sets the button external-reset flag |
| sys_rst_req | output | 1 | One-cycle system reset request |
| por_count | output | CNT_W | Saturating count of system resets since the last power-on arming |

## Verification
The embedded properties are evaluated on every cycle. They cover the address decode guarding state and pulse, the clear-to-zero and pulse after a power-on request, the counter holding steady on an external-reset request, the reload of the word on a first reset, its retention on later resets, counter saturation, and the one-clear of bit 31.

Only the bench scenarios can show the full masking algebra of the word. The bench sweeps all 32 settings of the five meaningful bits as the starting word against all 32 write patterns. Other properties need a sequence of steps rather than a single cycle: the arming sequence that turns a later reset back into a power-on, the lower-word read returning zero, and the event-over-write priority.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 3,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data,
  input  logic              sys_rst_evt,
  input  logic              btn_por_set,
  input  logic              btn_xir_set,
  output logic              sys_rst_req,
  output logic [CNT_W-1:0]  por_count
);
  localparam int B_POR  = 31;
  localparam int B_SPOR = 30;
  localparam int B_SXIR = 29;
  localparam int B_BPOR = 28;
  localparam int B_BXIR = 27;
  localparam logic [31:0] KEEP_M = 32'hF800_0000;
  localparam logic [31:0] W1C_M  = (32'd1 << B_POR) | (32'd1 << B_BPOR) | (32'd1 << B_BXIR);
  localparam logic [31:0] SET_M  = (32'd1 << B_SPOR) | (32'd1 << B_SXIR);
  localparam logic [31:0] POR_ONLY = 32'd1 << B_POR;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [31:0] cause, cause_nxt, wm;
  logic        word_hit, wr_go;

  assign word_hit = (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]) && addr[2];
  assign wr_go    = wr_en && word_hit && !sys_rst_evt;
  assign wm       = wdata & KEEP_M;
  assign rd_data  = word_hit ? cause : 32'd0;

  always_comb begin
    cause_nxt = cause;
    if (sys_rst_evt) begin
      if (por_count == '0) cause_nxt = POR_ONLY;
    end else if (wr_go) begin
      cause_nxt = (cause & ~(wm & W1C_M)) | (wm & SET_M);
    end
    if (btn_por_set) cause_nxt[B_BPOR] = 1'b1;
    if (btn_xir_set) cause_nxt[B_BXIR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause       <= '0;
      por_count   <= '0;
      sys_rst_req <= 1'b0;
    end else begin
      cause       <= cause_nxt;
      sys_rst_req <= wr_go && (wm[B_SPOR] || wm[B_SXIR]);
      if (sys_rst_evt) begin
        if (por_count != CNT_MAX) por_count <= por_count + 1'b1;
      end else if (wr_go && wm[B_SPOR]) begin
        por_count <= '0;
      end
    end
  end

  a_r2_decode_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && word_hit) && !sys_rst_evt && !btn_por_set && !btn_xir_set)
      |=> ($stable(rd_data) || !word_hit) && $stable(por_count) && !sys_rst_req);

  a_r3_por_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_hit && wdata[B_POR] && !sys_rst_evt) |=> !cause[B_POR]);

  a_r5_spor_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_hit && wdata[B_SPOR] && !sys_rst_evt) |=> (por_count == '0) && sys_rst_req);

  a_r6_sxir_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_hit && wdata[B_SXIR] && !wdata[B_SPOR] && !sys_rst_evt)
      |=> sys_rst_req && $stable(por_count));

  a_r8_first_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_evt && por_count == '0 && !btn_por_set && !btn_xir_set) |=> cause == POR_ONLY);

  a_r9_later_reset_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_evt && por_count != '0 && !btn_por_set && !btn_xir_set) |=> $stable(cause));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_evt && por_count == CNT_MAX) |=> por_count == CNT_MAX);

  a_r13_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_evt && wr_en) |=> !sys_rst_req);
endmodule

// File: tb/sim_rst_cause_reg.sv
`timescale 1ns/1ps
module sim_rst_cause_reg;
  logic clk = 0, rst_n = 0;
  logic [15:0] addr = 16'h0;
  logic wr_en = 0, sys_rst_evt = 0, btn_por_set = 0, btn_xir_set = 0;
  logic [31:0] wdata = 0, rd_data;
  logic sys_rst_req;
  logic [2:0] por_count;

  logic [31:0] mreg;
  logic [2:0]  mcnt;
  logic        mpulse;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  rst_cause_reg u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_data(rd_data), .sys_rst_evt(sys_rst_evt), .btn_por_set(btn_por_set),
    .btn_xir_set(btn_xir_set), .sys_rst_req(sys_rst_req), .por_count(por_count));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic hit(input logic [15:0] a);
    return (a[15:3] == 13'h1E04) && a[2];
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] m;
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    m = d & 32'hF800_0000;
    mpulse = hit(a) && (m[30] || m[29]);
    if (hit(a)) begin
      mreg = (mreg & ~(m & 32'h9800_0000)) | (m & 32'h6000_0000);
      if (m[30]) mcnt = 3'd0;
    end
  endtask

  task automatic evt();
    sys_rst_evt = 1;
    @(negedge clk);
    sys_rst_evt = 0;
    if (mcnt == 3'd0) mreg = 32'h8000_0000;
    if (mcnt != 3'd7) mcnt = mcnt + 3'd1;
    mpulse = 0;
  endtask

  task automatic hook(input logic por_b, input logic xir_b);
    btn_por_set = por_b; btn_xir_set = xir_b;
    @(negedge clk);
    btn_por_set = 0; btn_xir_set = 0;
    if (por_b) mreg[28] = 1'b1;
    if (xir_b) mreg[27] = 1'b1;
    mpulse = 0;
  endtask

  task automatic state(input string req);
    addr = 16'hF024; #0.5;
    chk(req, rd_data, mreg);
    chk(req, {29'd0, por_count}, {29'd0, mcnt});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    mreg = 0; mcnt = 0; mpulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    state("R1");
    chk("R1 pulse", {31'd0, sys_rst_req}, 32'd0);

    evt();
    state("R8 first reset");
    wr(16'hF024, 32'h2000_0000);
    chk("R6 pulse", {31'd0, sys_rst_req}, 32'd1);
    state("R6 count kept");
    @(negedge clk);
    chk("R7 single cycle", {31'd0, sys_rst_req}, 32'd0);
    evt();
    state("R9 later reset keeps");

    wr(16'hF024, 32'hFFFF_FFFF);
    chk("R5 pulse", {31'd0, sys_rst_req}, 32'd1);
    state("R5 R4 R3 all ones");
    wr(16'hF024, 32'h0000_0000);
    chk("R7 no request", {31'd0, sys_rst_req}, 32'd0);
    state("R4 zeros keep set bits");

    foreach (mreg[i]) ;
    begin
      logic [15:0] bad [5];
      bad[0] = 16'hF020; bad[1] = 16'hF028; bad[2] = 16'hF01C; bad[3] = 16'h0024; bad[4] = 16'hE024;
      for (int k = 0; k < 5; k++) begin
        wr(bad[k], 32'hFFFF_FFFF);
        chk("R2 no pulse", {31'd0, sys_rst_req}, 32'd0);
        state("R2 no effect");
        addr = bad[k]; #0.5;
        chk("R11 other address reads zero", rd_data, 32'd0);
      end
    end

    for (int n = 0; n < 9; n++) evt();
    state("R10 saturated");
    chk("R10 count max", {29'd0, por_count}, 32'd7);

    addr = 16'hF024; wdata = 32'hC000_0000; wr_en = 1; sys_rst_evt = 1;
    @(negedge clk);
    wr_en = 0; sys_rst_evt = 0;
    chk("R13 no pulse", {31'd0, sys_rst_req}, 32'd0);
    state("R13 write discarded");

    hook(1, 1);
    state("R12 hooks set");
    addr = 16'hF024; wdata = 32'h1800_0000; wr_en = 1; btn_por_set = 1;
    @(negedge clk);
    wr_en = 0; btn_por_set = 0;
    mreg[27] = 1'b0;
    state("R12 set beats clear");

    for (int s = 0; s < 32; s++) begin
      for (int w = 0; w < 32; w++) begin
        wr(16'hF024, 32'h4000_0000);
        evt();
        if (!s[4]) wr(16'hF024, 32'h8000_0000);
        if (s[1] || s[0]) hook(s[1], s[0]);
        if (s[3] || s[2]) wr(16'hF024, {1'b0, s[3], s[2], 29'd0});
        wr(16'hF024, {w[4:0], 27'd0});
        chk("R3 R4 R5 R6 sweep pulse", {31'd0, sys_rst_req}, {31'd0, mpulse});
        state("R3 R4 R5 R6 sweep");
      end
    end

    addr = 16'hF020; #0.5;
    chk("R11 lower word zero", rd_data, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule